// File: doc/BRIEF.md
# Programmable AND-Array Logic Block with Output Macrocells

This block is a small programmable sum-of-products device. A set of dedicated inputs and the macrocell feedback signals are each offered in true and inverted form to a programmable AND array. Each product term is formed from a set of those literals chosen by configuration bits. Product terms are gathered in fixed groups, and each group is ORed into one output macrocell. The OR grouping cannot be changed. Each macrocell either passes its sum straight to its output or presents the value that its D flip-flop holds. It also has an output-enable bit. The macrocell's flip-flop value is routed back into the AND array as an extra signal.

The configuration is a single serial chain. While `cfg_en` is high, one bit is taken from `cfg_din` on every rising clock edge. The AND-array bits come first and the per-macrocell mode and enable bits come last. During loading, the logic outputs are forced low and every macrocell flip-flop is cleared, so a freshly loaded pattern starts from a known state.

Top module: `pal_device`

## Requirements
- R1: A synchronous active-high `rst` clears every macrocell flip-flop and the whole configuration. After reset, every `pad_out` and `oe` bit reads 0.
- R2: While `cfg_en` is high, each rising edge shifts in one bit from `cfg_din`. Stream position k (0 = first bit shifted) is defined as follows. k = p*16 + c is the AND-array bit for product term p and literal column c. Position 256 + 2*m is the mode bit of macrocell m (1 = registered). Position 256 + 2*m + 1 is the enable bit of macrocell m. The load takes 264 bits.
- R3: While `cfg_en` is high, every `pad_out` and `oe` bit is 0. Every macrocell flip-flop is cleared on each edge on which `cfg_en` is high.
- R4: Literal column c = 2*s selects signal s in true form, and column c = 2*s+1 selects it in inverted form. Signals s = 0..3 are `in_pins[s]` and signals s = 4..7 are the feedback of macrocells 0..3. A product term is the AND of all its selected literals.
- R5: A product term with no literal selected evaluates to 0. This includes the case where a macrocell has no term programmed at all.
- R6: Macrocell m sums only product terms 4*m to 4*m+3.
- R7: In combinational mode (mode bit 0), an enabled macrocell shows its current sum on `pad_out` in the same cycle as the input change.
- R8: In registered mode (mode bit 1), an enabled macrocell shows the sum captured at the most recent rising edge.
- R9: A macrocell whose enable bit is 0 shows `pad_out` = 0 and `oe` = 0. An enabled macrocell outside loading shows `oe` = 1.
- R10: Each macrocell flip-flop captures its sum on every edge outside reset and loading, in both modes. This flip-flop value is the macrocell's feedback signal, and the enable bit has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration data |
| in_pins | input | 4 | Dedicated logic inputs |
| pad_out | output | 4 | Macrocell outputs, forced to 0 when disabled |
| oe | output | 4 | Per-macrocell output-enable flag |

## Verification
Two hand-built patterns are each driven with an exhaustive sweep of all sixteen input values and then with random inputs.
- The sweep shows whether true and inverted literals are swapped and whether a term lands in the wrong OR group.
- A toggle built from a macrocell's own inverted feedback, and a set-latch built from its true feedback, show whether feedback is taken from the flip-flop or from the live sum.
- A combinational macrocell that reads another macrocell's feedback shows whether the flip-flop keeps capturing in combinational mode.
- A term that selects both polarities of one signal, and a term with no literals, separate a real empty-term-is-zero rule from an accidental one.

A third, randomly filled pattern checks the slot ordering of the whole configuration stream. A reset issued in the middle of operation confirms that the configuration is lost.

// File: rtl/pal_pkg.sv
package pal_pkg;

   typedef enum logic {
      MC_MODE_COMB = 1'b0,
      MC_MODE_REG  = 1'b1
   } mc_mode_e;

   // Position of an AND-array bit in the configuration stream.
   function automatic int and_slot(input int term, input int col, input int n_col);
      return term * n_col + col;
   endfunction

   // Position of a macrocell mode bit in the configuration stream.
   function automatic int mode_slot(input int mc, input int and_bits);
      return and_bits + 2 * mc;
   endfunction

   // Position of a macrocell enable bit in the configuration stream.
   function automatic int enable_slot(input int mc, input int and_bits);
      return and_bits + 2 * mc + 1;
   endfunction

endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
   parameter int LEN        = 264,
   parameter bit CFG_RETAIN = 1'b0
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] bits
);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("pal_cfg_chain: LEN must be at least 2");
      end

      if (CFG_RETAIN) begin : g_keep
         always_ff @(posedge clk) begin
            if (shift_en) bits <= {bits[LEN-2:0], din};
         end
      end else begin : g_clear
         always_ff @(posedge clk) begin
            if (rst)           bits <= '0;
            else if (shift_en) bits <= {bits[LEN-2:0], din};
         end
      end
   endgenerate

   AST_CHAIN_TAKES_BIT: assert property (@(posedge clk) disable iff (rst)
      ($past(shift_en) && !$past(rst)) |-> (bits[0] == $past(din)))
      else $error("chain did not take serial bit"); // R2

   AST_CHAIN_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!$past(shift_en) && !$past(rst)) |-> $stable(bits))
      else $error("chain moved without shift enable"); // R2

endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
   parameter int N_SIG  = 8,
   parameter int N_TERM = 16
) (
   input  logic                         clk,
   input  logic                         rst,
   input  logic [N_SIG-1:0]             sig,
   input  logic [N_TERM*2*N_SIG-1:0]    fuse,
   output logic [N_TERM-1:0]            term
);

   localparam int N_COL = 2 * N_SIG;

   logic [N_COL-1:0] lit;

   generate
      if (N_SIG < 1 || N_TERM < 1) begin : g_bad_size
         $error("pal_and_plane: sizes must be positive");
      end

      for (genvar s = 0; s < N_SIG; s++) begin : g_lit
         assign lit[2*s]   = sig[s];
         assign lit[2*s+1] = ~sig[s];
      end

      for (genvar p = 0; p < N_TERM; p++) begin : g_term
         logic [N_COL-1:0] mask;
         assign mask    = fuse[p*N_COL +: N_COL];
         assign term[p] = (|mask) & (&(lit | ~mask));

         AST_EMPTY_TERM_ZERO: assert property (@(posedge clk) disable iff (rst)
            (mask == '0) |-> !term[p])
            else $error("empty product term is high"); // R5
      end
   endgenerate

endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell #(
   parameter int N_PT = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            loading,
   input  logic [N_PT-1:0] terms,
   input  pal_pkg::mc_mode_e mode,
   input  logic            enable,
   output logic            pad,
   output logic            oe,
   output logic            fb
);

   logic sum;
   logic q;

   generate
      if (N_PT < 1) begin : g_bad_pt
         $error("pal_macrocell: N_PT must be positive");
      end

      if (N_PT == 1) begin : g_single
         assign sum = terms[0];
      end else begin : g_multi
         assign sum = |terms;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst || loading) q <= 1'b0;
      else                q <= sum;
   end

   always_comb begin
      pad = 1'b0;
      if (!loading && enable) begin
         pad = (mode == pal_pkg::MC_MODE_REG) ? q : sum;
      end
   end

   assign oe = enable & ~loading;
   assign fb = q;

   AST_FF_FOLLOWS_SUM: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(loading)) |-> (fb == $past(sum)))
      else $error("flip-flop missed its sum"); // R10

   AST_FF_CLEARED_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
      $past(loading) |-> !fb)
      else $error("flip-flop not cleared by loading"); // R3

   AST_OFF_PAD_LOW: assert property (@(posedge clk) disable iff (rst)
      !oe |-> !pad)
      else $error("disabled pad not low"); // R9

   AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (rst)
      loading |-> (!oe && !pad))
      else $error("output active while loading"); // R3

endmodule

// File: rtl/pal_device.sv
module pal_device #(
   parameter int N_IN       = 4,
   parameter int N_MC       = 4,
   parameter int PT_PER_MC  = 4,
   parameter bit CFG_RETAIN = 1'b0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            cfg_en,
   input  logic            cfg_din,
   input  logic [N_IN-1:0] in_pins,
   output logic [N_MC-1:0] pad_out,
   output logic [N_MC-1:0] oe
);

   localparam int N_SIG    = N_IN + N_MC;
   localparam int N_COL    = 2 * N_SIG;
   localparam int N_TERM   = N_MC * PT_PER_MC;
   localparam int AND_BITS = N_TERM * N_COL;
   localparam int CFG_LEN  = AND_BITS + 2 * N_MC;

   logic [CFG_LEN-1:0]  chain;
   logic [AND_BITS-1:0] fuse;
   logic [N_TERM-1:0]   term;
   logic [N_MC-1:0]     fb_q;
   logic [N_SIG-1:0]    sig;

   generate
      if (N_IN < 1 || N_MC < 1 || PT_PER_MC < 1) begin : g_bad_param
         $error("pal_device: all size parameters must be positive");
      end
   endgenerate

   pal_cfg_chain #(
      .LEN        (CFG_LEN),
      .CFG_RETAIN (CFG_RETAIN)
   ) u_chain (
      .clk      (clk),
      .rst      (rst),
      .shift_en (cfg_en),
      .din      (cfg_din),
      .bits     (chain)
   );

   // Stream bit k ends up at chain[CFG_LEN-1-k].
   generate
      for (genvar p = 0; p < N_TERM; p++) begin : g_fuse_row
         for (genvar c = 0; c < N_COL; c++) begin : g_fuse_col
            assign fuse[p*N_COL + c] =
               chain[CFG_LEN-1-pal_pkg::and_slot(p, c, N_COL)];
         end
      end
   endgenerate

   assign sig = {fb_q, in_pins};

   pal_and_plane #(
      .N_SIG  (N_SIG),
      .N_TERM (N_TERM)
   ) u_and (
      .clk  (clk),
      .rst  (rst),
      .sig  (sig),
      .fuse (fuse),
      .term (term)
   );

   generate
      for (genvar m = 0; m < N_MC; m++) begin : g_mc
         pal_pkg::mc_mode_e mode;
         logic              en;
         assign mode = pal_pkg::mc_mode_e'(chain[CFG_LEN-1-pal_pkg::mode_slot(m, AND_BITS)]);
         assign en   = chain[CFG_LEN-1-pal_pkg::enable_slot(m, AND_BITS)];

         pal_macrocell #(
            .N_PT (PT_PER_MC)
         ) u_mc (
            .clk     (clk),
            .rst     (rst),
            .loading (cfg_en),
            .terms   (term[m*PT_PER_MC +: PT_PER_MC]),
            .mode    (mode),
            .enable  (en),
            .pad     (pad_out[m]),
            .oe      (oe[m]),
            .fb      (fb_q[m])
         );
      end
   endgenerate

   AST_RESET_QUIET: assert property (@(posedge clk)
      ($past(rst) && !CFG_RETAIN && !cfg_en) |-> ((pad_out == '0) && (oe == '0)))
      else $error("outputs active right after reset"); // R1

endmodule

// File: tb/pal_device_bench.sv
module pal_device_bench;

   localparam int NI = 4;
   localparam int NM = 4;
   localparam int NP = 16;
   localparam int NC = 16;
   localparam int AB = NP * NC;
   localparam int CL = AB + 2 * NM;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          cfg_en = 1'b0;
   logic          cfg_din = 1'b0;
   logic [NI-1:0] in_pins = '0;
   logic [NM-1:0] pad_out;
   logic [NM-1:0] oe;

   bit            stream [CL];
   bit            cur    [CL];
   bit [NM-1:0]   qm;
   int            checks = 0;
   int            fails  = 0;
   bit            done   = 1'b0;

   always #4 clk = ~clk;

   pal_device u_pal_device (
      .clk     (clk),
      .rst     (rst),
      .cfg_en  (cfg_en),
      .cfg_din (cfg_din),
      .in_pins (in_pins),
      .pad_out (pad_out),
      .oe      (oe)
   );

   function automatic bit [NM-1:0] model_sum(input bit [NI-1:0] inp, input bit [NM-1:0] q);
      bit [NM-1:0] r = '0;
      for (int p = 0; p < NP; p++) begin
         bit used = 1'b0;
         bit ok   = 1'b1;
         for (int c = 0; c < NC; c++) begin
            if (cur[p*NC + c]) begin
               int s = c / 2;
               bit v = (s < NI) ? inp[s] : q[s-NI];
               if (c % 2 == 1) v = ~v;
               used = 1'b1;
               if (!v) ok = 1'b0;
            end
         end
         if (used && ok) r[p/4] = 1'b1;
      end
      return r;
   endfunction

   task automatic clear_stream();
      for (int k = 0; k < CL; k++) stream[k] = 1'b0;
   endtask

   task automatic set_lit(input int p, input int s, input bit neg);
      stream[p*NC + 2*s + int'(neg)] = 1'b1;
   endtask

   task automatic set_mc(input int m, input bit regd, input bit en);
      stream[AB + 2*m]     = regd;
      stream[AB + 2*m + 1] = en;
   endtask

   // One clock: drive at the falling edge, check, then model the rising edge.
   task automatic cyc(input bit ce, input bit din, input bit r,
                      input bit [NI-1:0] inp, input string tag);
      bit [NM-1:0] s;
      bit [NM-1:0] ep;
      bit [NM-1:0] eo;
      @(negedge clk);
      cfg_en  = ce;
      cfg_din = din;
      rst     = r;
      in_pins = inp;
      #1;
      s  = model_sum(inp, qm);
      ep = '0;
      eo = '0;
      if (!ce) begin
         for (int m = 0; m < NM; m++) begin
            if (cur[AB + 2*m + 1]) begin
               eo[m] = 1'b1;
               ep[m] = cur[AB + 2*m] ? qm[m] : s[m];
            end
         end
      end
      checks++;
      if (pad_out !== ep || oe !== eo) begin
         fails++;
         $display("FAIL %s: pad_out=%b oe=%b expected pad_out=%b oe=%b",
                  tag, pad_out, oe, ep, eo);
      end
      @(posedge clk);
      if (r) begin
         qm = '0;
         for (int k = 0; k < CL; k++) cur[k] = 1'b0;
      end else if (ce) begin
         qm = '0;
      end else begin
         qm = s;
      end
   endtask

   task automatic load(input string tag);
      for (int k = 0; k < CL; k++) cyc(1'b1, stream[k], 1'b0, in_pins, tag);
      for (int k = 0; k < CL; k++) cur[k] = stream[k];
   endtask

   task automatic sweep(input string tag);
      for (int v = 0; v < 16; v++) cyc(1'b0, 1'b0, 1'b0, NI'(v), tag);
      for (int v = 15; v >= 0; v--) cyc(1'b0, 1'b0, 1'b0, NI'(v), tag);
      for (int i = 0; i < 24; i++) cyc(1'b0, 1'b0, 1'b0, NI'($urandom_range(0, 15)), tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  %0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      qm = '0;
      for (int k = 0; k < CL; k++) cur[k] = 1'b0;

      // R1: reset state
      cyc(1'b0, 1'b0, 1'b1, 4'b1111, "R1 reset");
      cyc(1'b0, 1'b0, 1'b1, 4'b0101, "R1 reset");
      cyc(1'b0, 1'b0, 1'b0, 4'b1010, "R1 after reset");

      // Pattern A: polarity, OR groups, toggle and feedback in combinational mode
      clear_stream();
      set_lit(0, 0, 1'b0); set_lit(0, 1, 1'b1);   // mc0: in0 & ~in1
      set_lit(1, 2, 1'b0); set_lit(1, 3, 1'b0);   //      | in2 & in3
      set_mc(0, 1'b0, 1'b1);
      set_lit(4, 5, 1'b1);                        // mc1: ~fb1 toggle
      set_mc(1, 1'b1, 1'b1);
      set_lit(8, 4, 1'b0);                        // mc2: fb0
      set_mc(2, 1'b0, 1'b1);
      set_lit(12, 0, 1'b0);                       // mc3: in0 but disabled
      set_mc(3, 1'b0, 1'b0);
      load("R3 R2 loading A");
      sweep("R4 R6 R7 R8 R9 R10 pattern A");

      // R1: reset in operation loses configuration
      cyc(1'b0, 1'b0, 1'b1, 4'b1111, "R1 mid reset");
      cyc(1'b0, 1'b0, 1'b0, 4'b1111, "R1 config cleared");
      cyc(1'b0, 1'b0, 1'b0, 4'b0001, "R1 config cleared");

      // Pattern B: registered OR, empty and contradictory terms, NOR, set latch
      clear_stream();
      set_lit(0, 0, 1'b0); set_lit(1, 1, 1'b0);   // mc0: in0 | in1 registered
      set_mc(0, 1'b1, 1'b1);
      set_lit(4, 2, 1'b0); set_lit(4, 2, 1'b1);   // mc1: in2 & ~in2, others empty
      set_mc(1, 1'b0, 1'b1);
      for (int s = 0; s < NI; s++) set_lit(8, s, 1'b1); // mc2: NOR of inputs
      set_mc(2, 1'b0, 1'b1);
      set_lit(12, 7, 1'b0); set_lit(13, 3, 1'b0); // mc3: fb3 | in3 registered
      set_mc(3, 1'b1, 1'b1);
      load("R3 R2 loading B");
      sweep("R5 R8 R4 R10 pattern B");

      // Pattern C: random configuration checks slot ordering
      clear_stream();
      for (int k = 0; k < AB; k++) stream[k] = ($urandom_range(0, 7) == 0);
      for (int k = AB; k < CL; k++) stream[k] = 1'($urandom_range(0, 1));
      load("R3 R2 loading C");
      sweep("R2 R4 R6 pattern C");

      // Reload during operation clears flip-flops, then pattern C resumes
      load("R3 reload");
      sweep("R3 R10 after reload");

      finish_run();
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not end, expected completion");
         finish_run();
      end
   end

endmodule